// File: doc/BRIEF.md
# Jittered Switching Oscillator with Light-Load Foldback

This block sets the switching rhythm of a fixed-frequency current-mode flyback controller. A phase accumulator advances by a frequency increment on every clock. Each wrap of the phase marks the start of a switching cycle, and crossing a fixed phase fraction marks the forced end of the on-time. The increment is reloaded only when the phase wraps. It is built from three parts: the nominal frequency option, a linear foldback driven by the feedback level, and a slow triangle that spreads the frequency over a ±6 % band.

The feedback level arrives as an unsigned millivolt code. The current-sense comparator reports its trip on `csTrip`. A cycle in which that trip never arrives before the on-time ceiling is counted as a maximum-duty cycle, and the next period then ignores foldback. Below a low feedback level the block enters a pulse-skipping state, with separate entry and exit levels. While in that state no cycle starts. The nominal option is chosen by the parameter `HIGH_FREQ`: 0 selects 65 kHz and 1 selects 100 kHz.

Top module: `fold_jitter_osc`

## Requirements
- R1: While `rst_n` is low, `cycleStart`, `dutyOff` and `skipActive` are all 0.
- R2: With feedback at or above 2000 mV and the current trip arriving every cycle, the mean switching period is CLK_KHZ/NOM_KHZ clocks. Every period lies within the jitter band around that mean.
- R3: Each started cycle gives exactly one `dutyOff` pulse, 80 % of the way through that cycle's period. The pulse never falls in the same clock as, or the clock right after, a `cycleStart`.
- R4: The period is spread by a triangle of ±6 % in frequency, and one full triangle lasts TRI_US microseconds. Within one triangle both the short extreme and the long extreme of the period occur.
- R5: For feedback between 1350 mV and 2000 mV, the frequency is linear in feedback, running from MIN_KHZ at 1350 mV up to the nominal frequency at 2000 mV.
- R6: At or below 1350 mV, and above the skip level, the frequency is the minimum of 27 kHz.
- R7: The jitter triangle stays active while the frequency is folded back.
- R8: When a cycle reaches the `dutyOff` point without `csTrip` having been seen since its start, the next period uses the nominal frequency whatever the feedback level is.
- R9: When feedback is below 700 mV, `skipActive` rises, and from the following clock no `cycleStart` is produced.
- R10: `skipActive` clears only when feedback is above 800 mV. Between 700 mV and 800 mV the skip state is held, whether it was set or clear.
- R11: The frequency increment changes only in the clock in which the phase wraps. A feedback change made mid-cycle therefore leaves the current period unchanged and takes effect from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fbMv | input | FB_W | Feedback level in millivolts, unsigned |
| csTrip | input | 1 | Current-sense comparator trip, ends the on-time |
| cycleStart | output | 1 | One-clock strobe that starts a switching cycle |
| dutyOff | output | 1 | One-clock strobe at the maximum-duty point |
| skipActive | output | 1 | High while pulse skipping is in force |

## Verification
The bench builds the block with CLK_KHZ=8000, TRI_US=2000 and HIGH_FREQ=0. This gives a nominal period of about 123 clocks and a minimum-frequency period of about 296 clocks. These bands are wide apart, so the nominal, folded and maximum-duty cases can each be told apart from one measured period. With the triangle shortened to 16,000 clocks, both extremes of the jitter show up inside one measuring window at the nominal frequency and again at the minimum frequency. The bench also shifts feedback through the foldback range, mixing random codes with directed values, and steps it across the skip hysteresis in both directions.

// File: rtl/osc_pkg.sv
package osc_pkg;

  // Fixed-point scaling of the jitter factor (value / 2**JIT_FRAC).
  localparam int JIT_FRAC = 10;
  // Fixed-point scaling of the foldback slope.
  localparam int SLOPE_SH = 12;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic foldBypass;  // last cycle ran to the duty ceiling: use nominal
    logic skipHold;    // pulse skipping in force: gate cycle starts
  } oscStrb_t;

endpackage

// File: rtl/osc_jitter.sv
module osc_jitter #(
  parameter int CLK_KHZ = 20000,
  parameter int TRI_US  = 8000,
  parameter int JIT_PCT = 6,
  localparam int JIT_MAX = (JIT_PCT << osc_pkg::JIT_FRAC) / 100,
  localparam int JIT_W   = $clog2(JIT_MAX + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic signed [JIT_W-1:0] jitVal
);

  // Four ramps of JIT_MAX steps make one full triangle.
  localparam longint TICK_L = (longint'(CLK_KHZ) * TRI_US) / 1000 / (4 * JIT_MAX);
  localparam int TICK = (TICK_L < 1) ? 1 : int'(TICK_L);
  localparam int TW = (TICK > 1) ? $clog2(TICK) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK - 1);
  localparam logic signed [JIT_W-1:0] J_HI = JIT_W'(JIT_MAX);
  localparam logic signed [JIT_W-1:0] J_LO = -J_HI;

  logic [TW-1:0] tickCnt;
  logic          goingUp;
  logic          stepNow;

  assign stepNow = (tickCnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tickCnt <= '0;
      goingUp <= 1'b1;
      jitVal  <= '0;
    end else begin
      tickCnt <= stepNow ? '0 : tickCnt + 1'b1;
      if (stepNow) begin
        if (goingUp) begin
          if (jitVal == J_HI) begin
            goingUp <= 1'b0;
            jitVal  <= jitVal - 1'b1;
          end else begin
            jitVal <= jitVal + 1'b1;
          end
        end else begin
          if (jitVal == J_LO) begin
            goingUp <= 1'b1;
            jitVal  <= jitVal + 1'b1;
          end else begin
            jitVal <= jitVal - 1'b1;
          end
        end
      end
    end
  end

  // R4: the triangle stays inside its band
  a_r4_tri_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (jitVal <= J_HI) && (jitVal >= J_LO));

  // R4: the triangle moves by at most one step per clock
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (jitVal == $past(jitVal)) || (jitVal == $past(jitVal) + 1'b1) ||
    (jitVal == $past(jitVal) - 1'b1));

endmodule

// File: rtl/osc_ctrl.sv
module osc_ctrl #(
  parameter int FB_W        = 12,
  parameter int SKIP_IN_MV  = 700,
  parameter int SKIP_OUT_MV = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FB_W-1:0]  fbMv,
  input  logic             csTrip,
  input  logic             cycleStart,
  input  logic             dutyOff,
  output osc_pkg::oscStrb_t strb,
  output logic             skipActive
);

  localparam logic [FB_W-1:0] SKIP_IN_C  = FB_W'(SKIP_IN_MV);
  localparam logic [FB_W-1:0] SKIP_OUT_C = FB_W'(SKIP_OUT_MV);

  logic tripSeen;
  logic maxHit;

  // Skip hysteresis: enter below the low level, leave above the high one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skipActive <= 1'b0;
    end else if (fbMv < SKIP_IN_C) begin
      skipActive <= 1'b1;
    end else if (fbMv > SKIP_OUT_C) begin
      skipActive <= 1'b0;
    end
  end

  // Maximum-duty detection: no trip between the start and the ceiling.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tripSeen <= 1'b0;
      maxHit   <= 1'b0;
    end else begin
      if (cycleStart) begin
        tripSeen <= csTrip;
      end else if (csTrip) begin
        tripSeen <= 1'b1;
      end
      if (dutyOff) begin
        maxHit <= !(tripSeen || csTrip);
      end
    end
  end

  assign strb.foldBypass = maxHit;
  assign strb.skipHold   = skipActive;

  // R9: no cycle starts once skipping was in force on the previous clock
  a_r9_no_start_in_skip: assert property (@(posedge clk) disable iff (!rst_n)
    $past(skipActive) |-> !cycleStart);

  // R9: skip is entered only from a level below the entry threshold
  a_r9_skip_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skipActive) |-> ($past(fbMv) < SKIP_IN_C));

  // R10: skip is left only from a level above the exit threshold
  a_r10_skip_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(skipActive) |-> ($past(fbMv) > SKIP_OUT_C));

endmodule

// File: rtl/osc_datapath.sv
module osc_datapath #(
  parameter int CLK_KHZ    = 20000,
  parameter int NOM_KHZ    = 65,
  parameter int MIN_KHZ    = 27,
  parameter int PHASE_W    = 20,
  parameter int FB_W       = 12,
  parameter int DUTY_PCT   = 80,
  parameter int FOLD_HI_MV = 2000,
  parameter int FOLD_LO_MV = 1350,
  parameter int JIT_PCT    = 6,
  localparam int JIT_MAX = (JIT_PCT << osc_pkg::JIT_FRAC) / 100,
  localparam int JIT_W   = $clog2(JIT_MAX + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FB_W-1:0]         fbMv,
  input  logic signed [JIT_W-1:0] jitVal,
  input  osc_pkg::oscStrb_t       strb,
  output logic                    cycleStart,
  output logic                    dutyOff
);

  localparam int IW = PHASE_W;
  localparam int SW = IW + osc_pkg::SLOPE_SH;
  localparam int PW = IW + JIT_W + 1;
  localparam longint PH_ONE    = longint'(1) << PHASE_W;
  localparam longint NOM_INC_L = (longint'(NOM_KHZ) * PH_ONE) / CLK_KHZ;
  localparam longint MIN_INC_L = (longint'(MIN_KHZ) * PH_ONE) / CLK_KHZ;
  localparam longint SLOPE_L   = ((NOM_INC_L - MIN_INC_L) << osc_pkg::SLOPE_SH)
                                 / longint'(FOLD_HI_MV - FOLD_LO_MV);
  localparam longint INC_LO_L  = MIN_INC_L - ((MIN_INC_L * JIT_MAX) >> osc_pkg::JIT_FRAC) - 2;
  localparam longint INC_HI_L  = NOM_INC_L + ((NOM_INC_L * JIT_MAX) >> osc_pkg::JIT_FRAC) + 2;

  localparam logic [IW-1:0]   NOM_INC   = IW'(NOM_INC_L);
  localparam logic [IW-1:0]   MIN_INC   = IW'(MIN_INC_L);
  localparam logic [IW-1:0]   INC_LO    = IW'(INC_LO_L);
  localparam logic [IW-1:0]   INC_HI    = IW'(INC_HI_L);
  localparam logic [SW-1:0]   SLOPE     = SW'(SLOPE_L);
  localparam logic [IW-1:0]   DUTY_C    = IW'((PH_ONE * DUTY_PCT) / 100);
  localparam logic [FB_W-1:0] FOLD_HI_C = FB_W'(FOLD_HI_MV);
  localparam logic [FB_W-1:0] FOLD_LO_C = FB_W'(FOLD_LO_MV);

  logic [IW-1:0]      phase;
  logic [IW-1:0]      incCur;
  logic [IW:0]        phSum;
  logic               wrapEv;
  logic               dutyEv;
  logic               onCycle;
  logic [FB_W-1:0]    fbDelta;
  logic [FB_W+SW-1:0] foldProd;
  logic [IW-1:0]      foldInc;
  logic [IW-1:0]      baseInc;
  logic signed [PW-1:0] jitProd;
  logic [IW-1:0]      nextInc;

  assign phSum  = {1'b0, phase} + {1'b0, incCur};
  assign wrapEv = phSum[IW];
  assign dutyEv = !wrapEv && (phase < DUTY_C) && (phSum[IW-1:0] >= DUTY_C);

  // Linear foldback of the increment (frequency) against feedback.
  always_comb begin
    fbDelta  = fbMv - FOLD_LO_C;
    foldProd = {{SW{1'b0}}, fbDelta} * {{FB_W{1'b0}}, SLOPE};
    if (fbMv >= FOLD_HI_C) begin
      foldInc = NOM_INC;
    end else if (fbMv <= FOLD_LO_C) begin
      foldInc = MIN_INC;
    end else begin
      foldInc = MIN_INC + IW'(foldProd >> osc_pkg::SLOPE_SH);
    end
  end

  // Jitter scales whatever increment the foldback picked.
  always_comb begin
    baseInc = strb.foldBypass ? NOM_INC : foldInc;
    jitProd = $signed({{(JIT_W + 1){1'b0}}, baseInc}) *
              $signed({{(IW + 1){jitVal[JIT_W-1]}}, jitVal});
    nextInc = baseInc + IW'(jitProd >>> osc_pkg::JIT_FRAC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= '0;
      incCur     <= NOM_INC;
      onCycle    <= 1'b0;
      cycleStart <= 1'b0;
      dutyOff    <= 1'b0;
    end else begin
      phase      <= phSum[IW-1:0];
      cycleStart <= wrapEv && !strb.skipHold;
      dutyOff    <= dutyEv && onCycle;
      if (wrapEv) begin
        incCur  <= nextInc;
        onCycle <= !strb.skipHold;
      end else if (dutyEv) begin
        onCycle <= 1'b0;
      end
    end
  end

  // R11: the increment only moves in a clock where the phase wraps
  a_r11_inc_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (incCur != $past(incCur)) |-> $past(wrapEv));

  // R5: the increment stays within the folded and jittered range
  a_r5_inc_range: assert property (@(posedge clk) disable iff (!rst_n)
    (incCur >= INC_LO) && (incCur <= INC_HI));

  // R3: the duty ceiling never meets a cycle start or the clock after it
  a_r3_start_duty_apart: assert property (@(posedge clk) disable iff (!rst_n)
    cycleStart |-> !dutyOff);
  a_r3_duty_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    cycleStart |=> !dutyOff);

endmodule

// File: rtl/fold_jitter_osc.sv
module fold_jitter_osc #(
  parameter int CLK_KHZ     = 20000,
  parameter bit HIGH_FREQ   = 1'b0,
  parameter int MIN_KHZ     = 27,
  parameter int PHASE_W     = 20,
  parameter int FB_W        = 12,
  parameter int TRI_US      = 8000,
  parameter int JIT_PCT     = 6,
  parameter int DUTY_PCT    = 80,
  parameter int FOLD_HI_MV  = 2000,
  parameter int FOLD_LO_MV  = 1350,
  parameter int SKIP_IN_MV  = 700,
  parameter int SKIP_OUT_MV = 800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fbMv,
  input  logic            csTrip,
  output logic            cycleStart,
  output logic            dutyOff,
  output logic            skipActive
);

  localparam int NOM_KHZ = HIGH_FREQ ? 100 : 65;
  localparam int JIT_MAX = (JIT_PCT << osc_pkg::JIT_FRAC) / 100;
  localparam int JIT_W   = $clog2(JIT_MAX + 1) + 1;

  osc_pkg::oscStrb_t       strb;
  logic signed [JIT_W-1:0] jitVal;

  osc_jitter #(
    .CLK_KHZ(CLK_KHZ), .TRI_US(TRI_US), .JIT_PCT(JIT_PCT)
  ) uJit (
    .clk(clk), .rst_n(rst_n), .jitVal(jitVal)
  );

  osc_ctrl #(
    .FB_W(FB_W), .SKIP_IN_MV(SKIP_IN_MV), .SKIP_OUT_MV(SKIP_OUT_MV)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .fbMv(fbMv), .csTrip(csTrip),
    .cycleStart(cycleStart), .dutyOff(dutyOff),
    .strb(strb), .skipActive(skipActive)
  );

  osc_datapath #(
    .CLK_KHZ(CLK_KHZ), .NOM_KHZ(NOM_KHZ), .MIN_KHZ(MIN_KHZ),
    .PHASE_W(PHASE_W), .FB_W(FB_W), .DUTY_PCT(DUTY_PCT),
    .FOLD_HI_MV(FOLD_HI_MV), .FOLD_LO_MV(FOLD_LO_MV), .JIT_PCT(JIT_PCT)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .fbMv(fbMv), .jitVal(jitVal), .strb(strb),
    .cycleStart(cycleStart), .dutyOff(dutyOff)
  );

endmodule

// File: tb/sim_fold_jitter_osc.sv
`timescale 1ns/1ps
module sim_fold_jitter_osc;

  localparam int CLK_KHZ = 8000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] fbMv = 12'd2500;
  logic        csTrip = 1'b0;
  logic        cycleStart, dutyOff, skipActive;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // monitor state
  int  cyc = 0;
  int  lastStart = 0;
  int  lastPeriod = 0;
  bit  startValid = 1'b0;
  bit  statsEn = 1'b0;
  bit  tripEn = 1'b1;
  int  minP, maxP, minR, maxR;
  int  dPend = 0;
  bit  havD = 1'b0;
  int  startCnt = 0;
  int  dutyCnt = 0;

  always #2.5 clk = ~clk;

  fold_jitter_osc #(.CLK_KHZ(CLK_KHZ), .HIGH_FREQ(1'b0), .TRI_US(2000)) u0 (
    .clk(clk), .rst_n(rst_n), .fbMv(fbMv), .csTrip(csTrip),
    .cycleStart(cycleStart), .dutyOff(dutyOff), .skipActive(skipActive)
  );

  // Sampling and trip generation, away from the active edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (dutyOff) begin
      dutyCnt = dutyCnt + 1;
      dPend = cyc - lastStart;
      havD = 1'b1;
    end
    if (cycleStart) begin
      startCnt = startCnt + 1;
      if (startValid) begin
        lastPeriod = cyc - lastStart;
        if (statsEn) begin
          if (lastPeriod < minP) minP = lastPeriod;
          if (lastPeriod > maxP) maxP = lastPeriod;
          if (havD) begin
            int r;
            r = (dPend * 1000) / lastPeriod;
            if (r < minR) minR = r;
            if (r > maxR) maxR = r;
          end
        end
      end
      lastStart = cyc;
      startValid = 1'b1;
      havD = 1'b0;
    end
    csTrip <= tripEn && startValid && ((cyc - lastStart) == 3);
  end

  function automatic real expFreq(input int fb);
    if (fb >= 2000) return 65.0;
    if (fb <= 1350) return 27.0;
    return 27.0 + 38.0 * real'(fb - 1350) / 650.0;
  endfunction

  function automatic int bandLo(input int fb);
    return int'((real'(CLK_KHZ) / expFreq(fb)) / 1.065) - 2;
  endfunction

  function automatic int bandHi(input int fb);
    return int'((real'(CLK_KHZ) / expFreq(fb)) / 0.935) + 2;
  endfunction

  task automatic check(input string req, input int act, input int lo, input int hi);
    testsRun++;
    if (act < lo || act > hi) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
    end
  endtask

  task automatic measure(input int n);
    minP = 1 << 30; maxP = 0; minR = 1 << 30; maxR = 0;
    statsEn = 1'b1;
    repeat (n) @(negedge clk);
    statsEn = 1'b0;
  endtask

  task automatic waitStart();
    do begin
      @(negedge clk); #1;
    end while (!cycleStart);
  endtask

  task automatic periodBand(input string req, input int fb, input int n);
    fbMv = 12'(fb);
    repeat (900) @(negedge clk);
    measure(n);
    check(req, minP, bandLo(fb), bandHi(fb));
    check(req, maxP, bandLo(fb), bandHi(fb));
  endtask

  initial begin
    int rv;
    rv = $urandom(32'd42);
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 cycleStart", int'(cycleStart), 0, 0);
    check("R1 dutyOff", int'(dutyOff), 0, 0);
    check("R1 skipActive", int'(skipActive), 0, 0);
    rst_n = 1'b1;

    // R2 / R4 / R3: nominal frequency over a full triangle
    repeat (600) @(negedge clk);
    measure(17000);
    check("R2 min period", minP, bandLo(2500), 123);
    check("R2 max period", maxP, 123, bandHi(2500));
    check("R4 short extreme", minP, 0, 118);
    check("R4 long extreme", maxP, 129, 1000);
    check("R3 duty ratio min x1000", minR, 765, 835);
    check("R3 duty ratio max x1000", maxR, 765, 835);

    // R11: mid-cycle feedback change takes effect from the next period
    waitStart();
    repeat (3) @(negedge clk);
    fbMv = 12'd1350;
    waitStart();
    check("R11 current period kept", lastPeriod, bandLo(2500), bandHi(2500));
    waitStart();
    check("R11 next period folded", lastPeriod, bandLo(1350), bandHi(1350));

    // R6 and R7: minimum frequency with jitter still active
    repeat (600) @(negedge clk);
    measure(17000);
    check("R6 min period at 1350", minP, bandLo(1350), bandHi(1350));
    check("R6 max period at 1350", maxP, bandLo(1350), bandHi(1350));
    check("R7 short extreme folded", minP, 0, 284);
    check("R7 long extreme folded", maxP, 308, 1000);
    periodBand("R6 below fold end", 1000, 1500);

    // R5: directed and random points in the linear range
    periodBand("R5 mid fold", 1675, 1500);
    for (int i = 0; i < 4; i++) begin
      int fb;
      fb = 1400 + int'($urandom % 550);
      periodBand("R5 random fold", fb, 1200);
    end

    // R8: no trip -> duty ceiling reached -> nominal despite low feedback
    tripEn = 1'b0;
    fbMv = 12'd1350;
    repeat (1200) @(negedge clk);
    measure(1500);
    check("R8 min period at max duty", minP, bandLo(2500), bandHi(2500));
    check("R8 max period at max duty", maxP, bandLo(2500), bandHi(2500));
    tripEn = 1'b1;

    // R9: skip entry
    fbMv = 12'd650;
    repeat (400) @(negedge clk);
    check("R9 skip flag", int'(skipActive), 1, 1);
    startCnt = 0; dutyCnt = 0;
    repeat (2000) @(negedge clk);
    check("R9 no starts in skip", startCnt, 0, 0);
    check("R9 no duty strobes in skip", dutyCnt, 0, 0);

    // R10: hysteresis in both directions
    fbMv = 12'd750;
    startCnt = 0;
    repeat (2000) @(negedge clk);
    check("R10 held in skip", int'(skipActive), 1, 1);
    check("R10 no starts held", startCnt, 0, 0);
    fbMv = 12'd850;
    startCnt = 0;
    repeat (2000) @(negedge clk);
    check("R10 skip left", int'(skipActive), 0, 0);
    check("R10 starts resume", startCnt, 2, 100);
    fbMv = 12'd750;
    startCnt = 0;
    repeat (2000) @(negedge clk);
    check("R10 held out of skip", int'(skipActive), 0, 0);
    check("R10 starts continue", startCnt, 2, 100);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule